// File: doc/BRIEF.md
# Speculative Register Map Table with Pending-Writer Counters

This block is the register map table of a speculative thread. For every architectural register it holds the last committed value, the reorder buffer tag of the newest producer, and a count of speculative instructions that have been dispatched but not yet committed and that write the register. A consumer reads the table through a combinational read port. The port gives the committed value when no writer is pending. Otherwise it gives the producer tag, so the consumer can wait on that tag.

A rename port records each newly dispatched instruction. A commit port retires one instruction per cycle and writes its result. A trace-speculation pulse freezes the table: later dispatches no longer raise counters, but commits keep draining them. A register whose outstanding writers have all retired then reads as ready at once. An invalidate pulse, used when the threads resynchronise after a misspeculation, discards all speculative state and lifts the freeze.

Top module: `reg_map_table`

## Requirements
- R1: After reset, every register reads as ready with value 0.
- R2: When not frozen, a rename of register r raises its pending count by one and stores the rename tag. A read of r then gives rd_ready=0 and rd_tag equal to the newest rename tag, with rd_data=0.
- R3: A commit to register r writes its data into the committed value and lowers the pending count by one. When the count reaches zero, a read gives rd_ready=1, rd_data equal to the last committed data, and rd_tag=0.
- R4: A commit to a register whose count is zero leaves the count at zero (no wrap) and still writes the committed value.
- R5: If a rename and a commit target the same register in one cycle, the count is unchanged and the stored tag becomes the rename tag.
- R6: A commit clears the stored tag to 0 only when the commit tag equals the stored tag. Otherwise the stored tag is kept.
- R7: After a trace_spec pulse, renames change neither count nor tag, and commits keep lowering counts until they reach zero.
- R8: An invalidate pulse sets every count and tag to zero and clears the freeze, and keeps committed values. It overrides a rename, commit or trace_spec in the same cycle.
- R9: A pending count saturates at its maximum of 63 (6 bits) and does not wrap on further renames.
- R10: The read port is combinational on the registered state: rd_* reflect the table as it stood after the last clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | A speculative instruction is dispatched this cycle |
| ren_reg | input | 5 | Destination register of the dispatched instruction |
| ren_tag | input | 5 | Reorder buffer tag of the dispatched instruction |
| cmt_valid | input | 1 | An instruction commits this cycle |
| cmt_reg | input | 5 | Destination register of the committing instruction |
| cmt_tag | input | 5 | Reorder buffer tag of the committing instruction |
| cmt_data | input | 32 | Result written by the committing instruction |
| trace_spec | input | 1 | Trace speculation event; freezes counter increments |
| invalidate | input | 1 | Resynchronisation; drops speculative state |
| rd_reg | input | 5 | Register to read |
| rd_ready | output | 1 | 1 when no writer of rd_reg is pending |
| rd_data | output | 32 | Committed value when ready, else 0 |
| rd_tag | output | 5 | Stored producer tag when not ready, else 0 |

## Verification
On every cycle, the assertions check that a count moves by at most one and never wraps below zero or above its maximum. They also check that a frozen count never rises, that invalidate leaves every count, tag and the freeze cleared, and that a register reads as ready exactly when it has no pending writer. Some behaviour only shows across a sequence, and the directed scenarios cover it: tag selection when rename and commit collide, tag clearing on matching and mismatching commits, draining after a freeze, invalidate winning over simultaneous events, and saturation after 64 renames.

// File: rtl/rmt_pkg.sv
package rmt_pkg;
    localparam int DATA_W    = 32;
    localparam int ROB_DEPTH = 32;
    localparam int TAG_W     = $clog2(ROB_DEPTH);
    localparam int CNT_W     = $clog2(ROB_DEPTH) + 1;

    typedef logic [DATA_W-1:0] data_t;
    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    typedef struct packed {
        data_t value;
        tag_t  tag;
        cnt_t  pending;
    } map_entry_t;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'b00,
        CNT_DEC  = 2'b01,
        CNT_INC  = 2'b10,
        CNT_BOTH = 2'b11
    } cnt_op_e;

    localparam cnt_t CNT_MAX = {CNT_W{1'b1}};

    function automatic cnt_t next_pending(cnt_t cur, cnt_op_e op);
        cnt_t res;
        case (op)
            CNT_INC: res = (cur == CNT_MAX) ? cur : cur + cnt_t'(1);
            CNT_DEC: res = (cur == '0) ? cur : cur - cnt_t'(1);
            default: res = cur;
        endcase
        return res;
    endfunction
endpackage

// File: rtl/rmt_entry.sv
module rmt_entry
    import rmt_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       frozen,
    input  logic       inval,
    input  logic       ren_hit,
    input  tag_t       ren_tag,
    input  logic       cmt_hit,
    input  tag_t       cmt_tag,
    input  data_t      cmt_data,
    output map_entry_t entry
);
    logic    inc;
    cnt_op_e op;

    assign inc = ren_hit && !frozen;
    assign op  = cnt_op_e'({inc, cmt_hit});

    always_ff @(posedge clk) begin
        if (rst) begin
            entry <= '0;
        end else if (inval) begin
            entry.pending <= '0;
            entry.tag     <= '0;
        end else begin
            entry.pending <= next_pending(entry.pending, op);
            if (cmt_hit)
                entry.value <= cmt_data;
            if (inc)
                entry.tag <= ren_tag;
            else if (cmt_hit && entry.tag == cmt_tag)
                entry.tag <= '0;
        end
    end

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (rst)
        !inval |=> (entry.pending == $past(entry.pending)
                 || entry.pending == $past(entry.pending) + cnt_t'(1)
                 || entry.pending == $past(entry.pending) - cnt_t'(1)));

    // R4
    no_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        (entry.pending == '0 && !ren_hit) |=> entry.pending != CNT_MAX);

    // R7
    frozen_no_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen && !inval) |=> entry.pending <= $past(entry.pending));

    // R8
    inval_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inval |=> (entry.pending == '0 && entry.tag == '0));

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst)
        (entry.pending == CNT_MAX && !inval) |=> entry.pending >= CNT_MAX - cnt_t'(1));
endmodule

// File: rtl/rmt_read_port.sv
module rmt_read_port
    import rmt_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  map_entry_t [NUM_REGS-1:0] table_q,
    input  logic [IDX_W-1:0]          rd_reg,
    output logic                      rd_ready,
    output data_t                     rd_data,
    output tag_t                      rd_tag
);
    map_entry_t sel;

    always_comb begin
        sel      = table_q[rd_reg];
        rd_ready = (sel.pending == '0);
        rd_data  = rd_ready ? sel.value : '0;
        rd_tag   = rd_ready ? '0 : sel.tag;
    end
endmodule

// File: rtl/reg_map_table.sv
module reg_map_table
    import rmt_pkg::*;
#(
    parameter int NUM_REGS = 32,
    localparam int IDX_W   = $clog2(NUM_REGS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ren_valid,
    input  logic [IDX_W-1:0]     ren_reg,
    input  logic [TAG_W-1:0]     ren_tag,
    input  logic                 cmt_valid,
    input  logic [IDX_W-1:0]     cmt_reg,
    input  logic [TAG_W-1:0]     cmt_tag,
    input  logic [DATA_W-1:0]    cmt_data,
    input  logic                 trace_spec,
    input  logic                 invalidate,
    input  logic [IDX_W-1:0]     rd_reg,
    output logic                 rd_ready,
    output logic [DATA_W-1:0]    rd_data,
    output logic [TAG_W-1:0]     rd_tag
);
    logic                      frozen_q;
    map_entry_t [NUM_REGS-1:0] table_q;

    always_ff @(posedge clk) begin
        if (rst || invalidate)
            frozen_q <= 1'b0;
        else if (trace_spec)
            frozen_q <= 1'b1;
    end

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_entry
        rmt_entry u_entry (
            .clk      (clk),
            .rst      (rst),
            .frozen   (frozen_q),
            .inval    (invalidate),
            .ren_hit  (ren_valid && ren_reg == IDX_W'(g)),
            .ren_tag  (ren_tag),
            .cmt_hit  (cmt_valid && cmt_reg == IDX_W'(g)),
            .cmt_tag  (cmt_tag),
            .cmt_data (cmt_data),
            .entry    (table_q[g])
        );
    end

    rmt_read_port #(.NUM_REGS(NUM_REGS)) u_read (
        .table_q  (table_q),
        .rd_reg   (rd_reg),
        .rd_ready (rd_ready),
        .rd_data  (rd_data),
        .rd_tag   (rd_tag)
    );

    // R8
    freeze_release_chk: assert property (@(posedge clk) disable iff (rst)
        invalidate |=> !frozen_q);

    // R7
    freeze_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (frozen_q && !invalidate) |=> frozen_q);

    // R10
    ready_view_chk: assert property (@(posedge clk) disable iff (rst)
        rd_ready |-> (table_q[rd_reg].pending == '0 && rd_tag == '0));
endmodule

// File: tb/reg_map_table_test.sv
module reg_map_table_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        ren_valid, cmt_valid, trace_spec, invalidate;
    logic [4:0]  ren_reg, ren_tag, cmt_reg, cmt_tag, rd_reg;
    logic [31:0] cmt_data;
    logic        rd_ready;
    logic [31:0] rd_data;
    logic [4:0]  rd_tag;

    int tests  = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    reg_map_table uut (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_reg(ren_reg), .ren_tag(ren_tag),
        .cmt_valid(cmt_valid), .cmt_reg(cmt_reg), .cmt_tag(cmt_tag), .cmt_data(cmt_data),
        .trace_spec(trace_spec), .invalidate(invalidate),
        .rd_reg(rd_reg), .rd_ready(rd_ready), .rd_data(rd_data), .rd_tag(rd_tag)
    );

    task automatic idle_inputs();
        ren_valid = 0; ren_reg = 0; ren_tag = 0;
        cmt_valid = 0; cmt_reg = 0; cmt_tag = 0; cmt_data = 0;
        trace_spec = 0; invalidate = 0;
    endtask

    task automatic cycle(input logic rv, input logic [4:0] rr, input logic [4:0] rt,
                         input logic cv, input logic [4:0] cr, input logic [4:0] ct,
                         input logic [31:0] cd, input logic ts, input logic inv);
        @(negedge clk);
        ren_valid = rv; ren_reg = rr; ren_tag = rt;
        cmt_valid = cv; cmt_reg = cr; cmt_tag = ct; cmt_data = cd;
        trace_spec = ts; invalidate = inv;
        @(posedge clk);
        #1;
        idle_inputs();
    endtask

    task automatic ren(input logic [4:0] r, input logic [4:0] t);
        cycle(1, r, t, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic cmt(input logic [4:0] r, input logic [4:0] t, input logic [31:0] d);
        cycle(0, 0, 0, 1, r, t, d, 0, 0);
    endtask

    task automatic expect_read(input logic [4:0] r, input logic er,
                               input logic [31:0] ed, input logic [4:0] et, input string req);
        rd_reg = r;
        #1;
        tests++;
        if (rd_ready !== er || rd_data !== ed || rd_tag !== et) begin
            fails++;
            $display("FAIL %s reg %0d: ready=%0b data=%h tag=%0d expected ready=%0b data=%h tag=%0d",
                     req, r, rd_ready, rd_data, rd_tag, er, ed, et);
        end
    endtask

    task automatic t_reset();
        expect_read(0, 1, 0, 0, "R1");
        expect_read(31, 1, 0, 0, "R1");
    endtask

    task automatic t_rename_commit();
        ren(3, 4);
        expect_read(3, 0, 0, 4, "R2");
        ren(3, 9);
        expect_read(3, 0, 0, 9, "R10");
        cmt(3, 4, 32'h11);
        expect_read(3, 0, 0, 9, "R6");
        cmt(3, 9, 32'h22);
        expect_read(3, 1, 32'h22, 0, "R3");
    endtask

    task automatic t_underflow();
        cmt(7, 0, 32'hAB);
        expect_read(7, 1, 32'hAB, 0, "R4");
        ren(7, 2);
        expect_read(7, 0, 0, 2, "R4");
        cmt(7, 2, 32'hCD);
        expect_read(7, 1, 32'hCD, 0, "R3");
    endtask

    task automatic t_tag_clear();
        ren(5, 3);
        ren(5, 7);
        cmt(5, 7, 32'h1);
        expect_read(5, 0, 0, 0, "R6");
        cmt(5, 3, 32'h2);
        expect_read(5, 1, 32'h2, 0, "R6");
    endtask

    task automatic t_same_cycle();
        ren(9, 1);
        cycle(1, 9, 6, 1, 9, 1, 32'h5, 0, 0);
        expect_read(9, 0, 0, 6, "R5");
        cmt(9, 6, 32'h8);
        expect_read(9, 1, 32'h8, 0, "R5");
    endtask

    task automatic t_freeze();
        ren(10, 2);
        ren(10, 3);
        cycle(0, 0, 0, 0, 0, 0, 0, 1, 0);
        ren(10, 12);
        expect_read(10, 0, 0, 3, "R7");
        cmt(10, 2, 32'h10);
        expect_read(10, 0, 0, 3, "R7");
        cmt(10, 3, 32'h20);
        expect_read(10, 1, 32'h20, 0, "R7");
        ren(11, 4);
        expect_read(11, 1, 0, 0, "R7");
    endtask

    task automatic t_invalidate();
        cycle(0, 0, 0, 0, 0, 0, 0, 0, 1);
        ren(12, 5);
        expect_read(12, 0, 0, 5, "R8");
        ren(13, 6);
        cycle(1, 14, 1, 1, 12, 5, 32'h99, 1, 1);
        expect_read(12, 1, 0, 0, "R8");
        expect_read(13, 1, 0, 0, "R8");
        expect_read(14, 1, 0, 0, "R8");
        expect_read(10, 1, 32'h20, 0, "R8");
        ren(15, 2);
        expect_read(15, 0, 0, 2, "R8");
        cmt(15, 2, 32'h3);
        expect_read(15, 1, 32'h3, 0, "R8");
    endtask

    task automatic t_saturate();
        for (int k = 0; k < 64; k++) ren(20, 5'(k));
        expect_read(20, 0, 0, 31, "R9");
        for (int k = 0; k < 62; k++) cmt(20, 0, 32'h0);
        expect_read(20, 0, 0, 31, "R9");
        cmt(20, 0, 32'h77);
        expect_read(20, 1, 32'h77, 0, "R9");
    endtask

    initial begin
        idle_inputs();
        rd_reg = 0;
        rst = 1;
        repeat (3) @(posedge clk);
        #1;
        rst = 0;
        t_reset();
        t_rename_commit();
        t_underflow();
        t_tag_clear();
        t_same_cycle();
        t_freeze();
        t_invalidate();
        t_saturate();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule